// File: doc/BRIEF.md
# PIO Strobe Timing Count Converter

This block turns the three nanosecond timing figures of a programmed-I/O transfer mode (address setup time, strobe active time and full cycle time) into the clock counts that a strobe timing generator is loaded with. A conversion starts with a single-cycle `start` pulse. The block divides each time by the bus clock period and rounds up. It then enforces the generator's lower and upper count limits and moves surplus recovery time into the active phase. Finally it encodes the result as two register bytes, which it presents with a one-cycle `done` pulse.

The block keeps the most recent unmerged counts for each of four drives. Drives 2 and 3 share one set of timing registers. When such a drive's partner is present, every count is widened to the slower of the two drives' values, so one register setting serves both. A silicon revision flag selects the later part's recovery encoding, in which the programmed value is one less than the wanted count.

Top module: `pio_count_converter`

## Requirements
- R1: Setup, active, recovery and cycle counts are the matching nanosecond figure divided by the clock period and rounded up to the next whole count.
- R2: Recovery time is the cycle time less the setup and active times, taken as 0 when negative. A second recovery candidate is the cycle count less the setup and active counts, also floored at 0. The larger candidate is used.
- R3: The active count and the recovery count are each raised to at least 2.
- R4: A recovery count above 17 adds its excess to the active count and is set to 17. After that, the active count is capped at 16.
- R5: When `late_rev` is 1, recovery is decremented by 1. In both revisions, recovery is then capped at 16, so 17 becomes 16 on the earlier revision.
- R6: A `clk_period_ns` of 0 selects a default period of 30 ns, which corresponds to a 33 MHz bus.
- R7: `setup_byte` bits 7:6 encode the setup count as follows: 4 gives 00, 3 gives 10, 1 or 2 gives 01, and 0 or any value of 5 or more gives 11. Bits 5:0 are 0.
- R8: `timing_byte` holds the active count in bits 7:4 and the recovery count in bits 3:0. A count of 16 is written as 0.
- R9: Each drive's stored counts are its own unmerged result from its last conversion. Reset loads setup 4, active 16 and recovery 16 for all four drives.
- R10: For drive 2 or 3 with `peer_present` at 1, each output count is the larger of the drive's own count and the stored count of its partner (index XOR 1). Drives 0 and 1, and any conversion with `peer_present` at 0, are not merged.
- R11: A `start` pulse while idle latches the inputs and raises `busy`. `done` pulses high for exactly one cycle, NS_W+1 clock edges after the start edge, and the byte outputs update at the same time. After reset, `busy`, `done` and both bytes are 0.
- R12: A `start` pulse while `busy` is high is ignored and does not change the result of the running conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launches a conversion when idle |
| setup_ns | input | NS_W | Address setup time, ns |
| active_ns | input | NS_W | Strobe active time, ns |
| cycle_ns | input | NS_W | Total cycle time, ns |
| clk_period_ns | input | NS_W | Bus clock period in ns; 0 selects the default |
| late_rev | input | 1 | Later silicon revision (recovery minus one) |
| drive_idx | input | 2 | Drive number, 0 to 3 |
| peer_present | input | 1 | Partner drive exists on the shared channel |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle result strobe |
| setup_byte | output | 8 | Encoded setup field in bits 7:6 |
| timing_byte | output | 8 | Active and recovery nibbles |

## Verification
The bench targets four failure areas.

- Recovery exactly at 17 and just above it. A design with a wrong comparison or a wrong excess transfer would give a different active nibble, or would leave a recovery of 17 that wraps to 1 in the nibble.
- A cycle time shorter than setup plus active. A design without the zero floor would produce a huge recovery and push active to 16.
- The merge, with a sequence on drives 2 and 3 and then on drive 0. A design that merged the wrong index, skipped the merge, stored merged instead of own counts, or merged drives 0 and 1 would return bytes that differ from the reset-valued or previously stored partner.
- A second `start` during a conversion. A design that accepted it would return the second vector's bytes.

// File: rtl/pio_cnt_pkg.sv
package pio_cnt_pkg;

   // Hardware limits of the strobe timing generator
   localparam int ACT_MIN   = 2;
   localparam int ACT_MAX   = 16;
   localparam int REC_MIN   = 2;
   localparam int REC_CAP   = 17;
   localparam int REC_MAX   = 16;
   localparam int SETUP_SAT = 5;

   typedef struct packed {
      logic [2:0] setup;
      logic [4:0] active;
      logic [4:0] recov;
   } drv_counts_t;

   localparam drv_counts_t SLOWEST_COUNTS = '{setup: 3'd4, active: 5'd16, recov: 5'd16};

endpackage

// File: rtl/pio_ceil_div.sv
// Iterative restoring divider producing ceil(num / den), one quotient bit per clock.
module pio_ceil_div #(
   parameter int W = 12
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         go,
   input  logic [W-1:0] num,
   input  logic [W-1:0] den,
   output logic         fin,
   output logic [W-1:0] quot
);
   localparam int CW = $clog2(W + 1);
   localparam int PW = 2 * W;

   logic [CW-1:0] steps_q;
   logic [W:0]    rem_q;
   logic [W-1:0]  quo_q;
   logic [W-1:0]  den_q;
   logic [W-1:0]  num_q;
   logic [W:0]    shifted;
   logic          fits;

   always_comb begin
      shifted = {rem_q[W-1:0], quo_q[W-1]};
      fits    = shifted >= {1'b0, den_q};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         steps_q <= '0;
         rem_q   <= '0;
         quo_q   <= '0;
         den_q   <= '0;
         num_q   <= '0;
         fin     <= 1'b0;
      end else begin
         fin <= 1'b0;
         if (go) begin
            steps_q <= CW'(W);
            rem_q   <= '0;
            quo_q   <= num;
            den_q   <= den;
            num_q   <= num;
         end else if (steps_q != '0) begin
            steps_q <= steps_q - 1'b1;
            if (fits) begin
               rem_q <= shifted - {1'b0, den_q};
               quo_q <= {quo_q[W-2:0], 1'b1};
            end else begin
               rem_q <= shifted;
               quo_q <= {quo_q[W-2:0], 1'b0};
            end
            if (steps_q == CW'(1)) fin <= 1'b1;
         end
      end
   end

   assign quot = quo_q + W'(rem_q != '0);

   // R6: the divisor handed to a conversion is never zero
   p_den_nonzero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      go |-> den != '0);

   // R1: result is the smallest count whose span covers the time
   p_ceil_cover_r1: assert property (@(posedge clk) disable iff (!rst_n)
      fin |-> (PW'(quot) * PW'(den_q) >= PW'(num_q)) &&
              ((quot == '0) || (PW'(quot - 1'b1) * PW'(den_q) < PW'(num_q))));

endmodule

// File: rtl/pio_count_shaper.sv
// Applies generator limits, recovery selection and excess transfer.
module pio_count_shaper
   import pio_cnt_pkg::*;
#(
   parameter int W = 12
) (
   input  logic [W-1:0] s_cnt,
   input  logic [W-1:0] a_cnt,
   input  logic [W-1:0] r_cnt,
   input  logic [W-1:0] c_cnt,
   input  logic         late_rev,
   output drv_counts_t  shaped
);
   localparam int XW = W + 2;
   localparam logic [XW-1:0] K_ACT_MIN   = XW'(ACT_MIN);
   localparam logic [XW-1:0] K_ACT_MAX   = XW'(ACT_MAX);
   localparam logic [XW-1:0] K_REC_MIN   = XW'(REC_MIN);
   localparam logic [XW-1:0] K_REC_CAP   = XW'(REC_CAP);
   localparam logic [XW-1:0] K_REC_MAX   = XW'(REC_MAX);
   localparam logic [XW-1:0] K_SETUP_SAT = XW'(SETUP_SAT);

   logic [XW-1:0] s_x, a_x, r_x, c_x;
   logic [XW-1:0] a_lo, sum_sa, r_alt, r_pick, r_lo, a_mv, r_mv, a_hi, r_rev, r_hi;

   always_comb begin
      s_x    = XW'(s_cnt);
      a_x    = XW'(a_cnt);
      r_x    = XW'(r_cnt);
      c_x    = XW'(c_cnt);
      a_lo   = (a_x < K_ACT_MIN) ? K_ACT_MIN : a_x;
      sum_sa = s_x + a_lo;
      r_alt  = (c_x > sum_sa) ? c_x - sum_sa : '0;
      r_pick = (r_x > r_alt) ? r_x : r_alt;
      r_lo   = (r_pick < K_REC_MIN) ? K_REC_MIN : r_pick;
      if (r_lo > K_REC_CAP) begin
         a_mv = a_lo + (r_lo - K_REC_CAP);
         r_mv = K_REC_CAP;
      end else begin
         a_mv = a_lo;
         r_mv = r_lo;
      end
      a_hi  = (a_mv > K_ACT_MAX) ? K_ACT_MAX : a_mv;
      r_rev = late_rev ? r_mv - 1'b1 : r_mv;
      r_hi  = (r_rev > K_REC_MAX) ? K_REC_MAX : r_rev;
      shaped.setup  = (s_x > K_SETUP_SAT) ? 3'(SETUP_SAT) : s_x[2:0];
      shaped.active = a_hi[4:0];
      shaped.recov  = r_hi[4:0];
   end

endmodule

// File: rtl/pio_count_store.sv
// Per-drive record of the last unmerged counts.
module pio_count_store
   import pio_cnt_pkg::*;
#(
   parameter int N_DRIVES = 4,
   localparam int IW = $clog2(N_DRIVES)
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic [IW-1:0] wr_idx,
   input  drv_counts_t wr_val,
   input  logic [IW-1:0] rd_idx,
   output drv_counts_t rd_val
);
   drv_counts_t slot [N_DRIVES];

   for (genvar g = 0; g < N_DRIVES; g++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                             slot[g] <= SLOWEST_COUNTS;
         else if (wr_en && wr_idx == IW'(g))     slot[g] <= wr_val;
      end
   end

   assign rd_val = slot[rd_idx];

endmodule

// File: rtl/pio_byte_encoder.sv
// Packs merged counts into the two register bytes.
module pio_byte_encoder
   import pio_cnt_pkg::*;
(
   input  drv_counts_t cnt,
   output logic [7:0]  setup_byte,
   output logic [7:0]  timing_byte
);
   logic [1:0] code;

   always_comb begin
      case (cnt.setup)
         3'd4:       code = 2'b00;
         3'd3:       code = 2'b10;
         3'd1, 3'd2: code = 2'b01;
         default:    code = 2'b11;
      endcase
      setup_byte  = {code, 6'b0};
      timing_byte = {cnt.active[3:0], cnt.recov[3:0]};
   end

endmodule

// File: rtl/pio_count_converter.sv
module pio_count_converter
   import pio_cnt_pkg::*;
#(
   parameter int NS_W              = 12,
   parameter int DEFAULT_PERIOD_NS = 30,
   parameter int N_DRIVES          = 4,
   parameter int SHARED_FIRST      = 2
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        start,
   input  logic [NS_W-1:0]             setup_ns,
   input  logic [NS_W-1:0]             active_ns,
   input  logic [NS_W-1:0]             cycle_ns,
   input  logic [NS_W-1:0]             clk_period_ns,
   input  logic                        late_rev,
   input  logic [$clog2(N_DRIVES)-1:0] drive_idx,
   input  logic                        peer_present,
   output logic                        busy,
   output logic                        done,
   output logic [7:0]                  setup_byte,
   output logic [7:0]                  timing_byte
);
   localparam int IW    = $clog2(N_DRIVES);
   localparam int N_DIV = 4;

   if (NS_W < 6 || NS_W > 16) begin : g_bad_width
      $error("NS_W must lie in 6..16");
   end
   if (DEFAULT_PERIOD_NS < 1 || DEFAULT_PERIOD_NS >= (1 << NS_W)) begin : g_bad_period
      $error("DEFAULT_PERIOD_NS must be nonzero and fit NS_W");
   end
   if (N_DRIVES < 2 || (N_DRIVES % 2) != 0 || (SHARED_FIRST % 2) != 0 ||
       SHARED_FIRST >= N_DRIVES) begin : g_bad_drives
      $error("drive count and shared base must be even, shared base below count");
   end

   logic            running;
   logic            rev_q, peer_q;
   logic [IW-1:0]   idx_q;
   logic            go;
   logic [NS_W:0]   sum_ns;
   logic [NS_W-1:0] rec_ns, per_ns;
   logic [NS_W-1:0] div_num [N_DIV];
   logic [NS_W-1:0] quot_v  [N_DIV];
   logic [N_DIV-1:0] fin_v;
   logic            all_fin;
   drv_counts_t     own_cnt, peer_cnt, merged;
   logic            merge_en;
   logic [7:0]      enc_setup, enc_timing;

   assign go = start && !running;

   always_comb begin
      sum_ns     = {1'b0, setup_ns} + {1'b0, active_ns};
      rec_ns     = ({1'b0, cycle_ns} > sum_ns) ? NS_W'({1'b0, cycle_ns} - sum_ns) : '0;
      per_ns     = (clk_period_ns == '0) ? NS_W'(DEFAULT_PERIOD_NS) : clk_period_ns;
      div_num[0] = setup_ns;
      div_num[1] = active_ns;
      div_num[2] = rec_ns;
      div_num[3] = cycle_ns;
   end

   for (genvar g = 0; g < N_DIV; g++) begin : g_div
      pio_ceil_div #(.W(NS_W)) i_div (
         .clk  (clk),
         .rst_n(rst_n),
         .go   (go),
         .num  (div_num[g]),
         .den  (per_ns),
         .fin  (fin_v[g]),
         .quot (quot_v[g])
      );
   end

   assign all_fin = &fin_v;

   pio_count_shaper #(.W(NS_W)) i_shaper (
      .s_cnt   (quot_v[0]),
      .a_cnt   (quot_v[1]),
      .r_cnt   (quot_v[2]),
      .c_cnt   (quot_v[3]),
      .late_rev(rev_q),
      .shaped  (own_cnt)
   );

   pio_count_store #(.N_DRIVES(N_DRIVES)) i_store (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (all_fin),
      .wr_idx(idx_q),
      .wr_val(own_cnt),
      .rd_idx(idx_q ^ IW'(1)),
      .rd_val(peer_cnt)
   );

   always_comb begin
      merge_en      = peer_q && (idx_q >= IW'(SHARED_FIRST));
      merged        = own_cnt;
      if (merge_en) begin
         if (peer_cnt.setup  > own_cnt.setup)  merged.setup  = peer_cnt.setup;
         if (peer_cnt.active > own_cnt.active) merged.active = peer_cnt.active;
         if (peer_cnt.recov  > own_cnt.recov)  merged.recov  = peer_cnt.recov;
      end
   end

   pio_byte_encoder i_enc (
      .cnt        (merged),
      .setup_byte (enc_setup),
      .timing_byte(enc_timing)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         running     <= 1'b0;
         rev_q       <= 1'b0;
         peer_q      <= 1'b0;
         idx_q       <= '0;
         done        <= 1'b0;
         setup_byte  <= '0;
         timing_byte <= '0;
      end else begin
         done <= all_fin;
         if (go) begin
            running <= 1'b1;
            rev_q   <= late_rev;
            peer_q  <= peer_present;
            idx_q   <= drive_idx;
         end else if (all_fin) begin
            running <= 1'b0;
         end
         if (all_fin) begin
            setup_byte  <= enc_setup;
            timing_byte <= enc_timing;
         end
      end
   end

   assign busy = running;

   // R11: accepted start raises busy on the next cycle
   p_go_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy);

   // R11: done is a single-cycle strobe
   p_done_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R1: the four dividers finish together
   p_div_lockstep_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (|fin_v) |-> (&fin_v));

   // R12: request fields stay frozen while a conversion runs
   p_start_ignored_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start) |=> ($stable(idx_q) && $stable(rev_q) && $stable(peer_q)));

   // R3/R4: merged active count lies within the generator's window
   p_active_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
      all_fin |-> (merged.active >= 5'd2 && merged.active <= 5'd16));

   // R5: merged recovery never exceeds the encodable maximum
   p_recov_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
      all_fin |-> (merged.recov >= 5'd1 && merged.recov <= 5'd16));

   // R10: merging never makes a count faster than the drive's own
   p_merge_slower_r10: assert property (@(posedge clk) disable iff (!rst_n)
      all_fin |-> (merged.setup >= own_cnt.setup && merged.active >= own_cnt.active &&
                   merged.recov >= own_cnt.recov));

endmodule

// File: tb/test_pio_count_converter.sv
module test_pio_count_converter;
   localparam int NS_W = 12;
   localparam int NV   = 11;

   typedef struct packed {
      logic [11:0] su;
      logic [11:0] ac;
      logic [11:0] cy;
      logic [11:0] pe;
      logic        rev;
      logic [1:0]  idx;
      logic [7:0]  eset;
      logic [7:0]  etim;
   } vec_t;

   // Drives 0/1 only, so no merging applies.
   localparam vec_t VECS [NV] = '{
      '{12'd70,  12'd165, 12'd600,  12'd30, 1'b0, 2'd0, 8'h80, 8'h6D}, // R1 plain division
      '{12'd25,  12'd70,  12'd120,  12'd30, 1'b1, 2'd1, 8'h40, 8'h31}, // R3 recovery raised to 2
      '{12'd30,  12'd60,  12'd900,  12'd30, 1'b0, 2'd0, 8'h40, 8'hC0}, // R8 recovery 16 -> nibble 0
      '{12'd100, 12'd300, 12'd1500, 12'd20, 1'b1, 2'd1, 8'hC0, 8'h00}, // R4 active capped at 16
      '{12'd70,  12'd165, 12'd600,  12'd0,  1'b1, 2'd0, 8'h80, 8'h6C}, // R6 default period
      '{12'd10,  12'd20,  12'd20,   12'd10, 1'b0, 2'd0, 8'h40, 8'h22}, // R2 negative recovery floored
      '{12'd0,   12'd45,  12'd180,  12'd15, 1'b0, 2'd1, 8'hC0, 8'h39}, // R7 setup 0
      '{12'd100, 12'd100, 12'd400,  12'd25, 1'b0, 2'd1, 8'h00, 8'h48}, // R7 setup 4
      '{12'd30,  12'd60,  12'd600,  12'd30, 1'b0, 2'd0, 8'h40, 8'h20}, // R5 seventeen capped
      '{12'd30,  12'd60,  12'd630,  12'd30, 1'b1, 2'd0, 8'h40, 8'h30}, // R5 eighteen moved, rev
      '{12'd25,  12'd70,  12'd120,  12'd30, 1'b0, 2'd1, 8'h40, 8'h32}  // R3 earlier revision
   };
   localparam string VTAG [NV] = '{"R1", "R3", "R8", "R4", "R6", "R2", "R7", "R7", "R5", "R5", "R3"};

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            start = 1'b0;
   logic [NS_W-1:0] setup_ns = '0, active_ns = '0, cycle_ns = '0, clk_period_ns = '0;
   logic            late_rev = 1'b0;
   logic [1:0]      drive_idx = '0;
   logic            peer_present = 1'b0;
   logic            busy, done;
   logic [7:0]      setup_byte, timing_byte;

   int n_cmp = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   pio_count_converter #(.NS_W(NS_W)) i_pio_count_converter (
      .clk(clk), .rst_n(rst_n), .start(start),
      .setup_ns(setup_ns), .active_ns(active_ns), .cycle_ns(cycle_ns),
      .clk_period_ns(clk_period_ns), .late_rev(late_rev), .drive_idx(drive_idx),
      .peer_present(peer_present), .busy(busy), .done(done),
      .setup_byte(setup_byte), .timing_byte(timing_byte));

   task automatic chk(input string tag, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic load(input int su, input int ac, input int cy, input int pe,
                       input logic rev, input int idx, input logic peer);
      setup_ns      = NS_W'(su);
      active_ns     = NS_W'(ac);
      cycle_ns      = NS_W'(cy);
      clk_period_ns = NS_W'(pe);
      late_rev      = rev;
      drive_idx     = 2'(idx);
      peer_present  = peer;
   endtask

   // Starts at a negedge, returns the edge count until done is seen.
   task automatic convert(input int su, input int ac, input int cy, input int pe,
                          input logic rev, input int idx, input logic peer, output int lat);
      load(su, ac, cy, pe, rev, idx, peer);
      start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      lat = 0;
      while (!done && lat < 100) begin
         @(posedge clk);
         lat++;
         @(negedge clk);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL R11 watchdog actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      int lat;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11 reset state
      chk("R11 reset busy", int'(busy), 0);
      chk("R11 reset done", int'(done), 0);
      chk("R11 reset setup_byte", int'(setup_byte), 0);
      chk("R11 reset timing_byte", int'(timing_byte), 0);

      // R9: drive 2 merged with untouched drive 3 reset counts 4/16/16
      convert(25, 70, 120, 30, 1'b1, 2, 1'b1, lat);
      chk("R9 reset peer setup", int'(setup_byte), 'h00);
      chk("R9 reset peer timing", int'(timing_byte), 'h00);
      // R10: no merge without peer; drive 2 now holds 1/3/1
      convert(25, 70, 120, 30, 1'b1, 2, 1'b0, lat);
      chk("R10 no peer setup", int'(setup_byte), 'h40);
      chk("R10 no peer timing", int'(timing_byte), 'h31);
      // R10: drive 3 (3/6/13) merged with drive 2 stored 1/3/1
      convert(70, 165, 600, 30, 1'b0, 3, 1'b1, lat);
      chk("R10 drive3 setup", int'(setup_byte), 'h80);
      chk("R10 drive3 timing", int'(timing_byte), 'h6D);
      // R9/R10: drive 2 merged with drive 3 stored own counts 3/6/13
      convert(25, 70, 120, 30, 1'b1, 2, 1'b1, lat);
      chk("R9 stored peer setup", int'(setup_byte), 'h80);
      chk("R9 stored peer timing", int'(timing_byte), 'h6D);
      // R10: drive 0 never merges even with peer flag (drive 1 holds 4/16/16)
      convert(25, 70, 120, 30, 1'b1, 0, 1'b1, lat);
      chk("R10 drive0 setup", int'(setup_byte), 'h40);
      chk("R10 drive0 timing", int'(timing_byte), 'h31);

      for (int v = 0; v < NV; v++) begin
         convert(int'(VECS[v].su), int'(VECS[v].ac), int'(VECS[v].cy), int'(VECS[v].pe),
                 VECS[v].rev, int'(VECS[v].idx), 1'b0, lat);
         chk({VTAG[v], " timing_byte"}, int'(timing_byte), int'(VECS[v].etim));
         chk("R7 setup_byte", int'(setup_byte), int'(VECS[v].eset));
         chk("R11 latency", lat, NS_W + 1);
      end

      // R12: second start during a run is ignored
      load(70, 165, 600, 30, 1'b0, 0, 1'b0);
      start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      repeat (3) @(negedge clk);
      chk("R11 busy during run", int'(busy), 1);
      load(30, 60, 900, 30, 1'b1, 1, 1'b0);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      lat = 0;
      while (!done && lat < 100) begin
         @(negedge clk);
         lat++;
      end
      chk("R12 first result setup", int'(setup_byte), 'h80);
      chk("R12 first result timing", int'(timing_byte), 'h6D);
      @(negedge clk);
      chk("R11 done single cycle", int'(done), 0);
      chk("R12 no second run", int'(busy), 0);
      repeat (NS_W + 3) @(negedge clk);
      chk("R12 no late done", int'(done), 0);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule